// File: doc/BRIEF.md
# Predicated Branch Sequencer

This block is the control-flow unit of a small stack processor. The program counter is not a separate register. It is the top entry of a small return-address stack, so a call only has to advance the stack pointer and a return only has to retreat it. On each step strobe the block reads the instruction word at its fetch address and acts on it. A plain word moves the counter forward by one. A jump or call word tests the top-of-stack data value against one of eight sign and zero predicates, and then either transfers control or falls through.

A branch word can also ask for one data-stack pop. The block raises a drop request in the same cycle as the step strobe, whatever the predicate outcome. The predicate is always judged on the top-of-stack value as it stood before the pop. The return flag comes from the non-branch word being executed. When it is set, control goes back to the entry below the top. Instruction memory, the data stack and the ALU sit outside the block.

Top module: `flow_sequencer`

## Requirements
- R1: After reset the fetch address is 0, the return stack pointer is 0 and the drop request is low.
- R2: A step with a non-branch word (bit 15 = 0) and the return flag low sets the fetch address to the old address plus one, modulo 1024, so 0x3FF is followed by 0x000.
- R3: A branch word carries its predicate in bits 13:11, and the predicate is judged on the 16-bit top-of-stack value as a signed number (bit 15 is the sign). The codes are: 0 never, 1 negative, 2 zero, 3 negative or zero, 4 positive, 5 non-zero, 6 zero or positive, 7 always.
- R4: A taken jump (bits 15:14 = 10) sets the fetch address to bits 9:0 of the word and leaves the stack pointer unchanged.
- R5: A taken call (bits 15:14 = 11) stores the caller's address plus one in the current entry, advances the pointer, and sets the fetch address to bits 9:0 of the word.
- R6: A branch whose predicate is false behaves like a plain word: the fetch address becomes the old address plus one and the stack does not move.
- R7: The drop request is high during a step whose word is a branch with bit 10 set, whether or not the branch is taken, and is low at all other times.
- R8: A step with a non-branch word and the return flag high moves the pointer back one entry, so the fetch address becomes the stored return address. The return flag has no effect when the word is a branch.
- R9: Without a step strobe, the fetch address and the stack pointer hold their values.
- R10: Calls nest to a depth of 15 below the entry in use at reset, and the matching returns restore the return addresses in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Execute the current instruction word on this edge |
| instr_i | input | 16 | Instruction word fetched from fetch_addr_o |
| tos_i | input | 16 | Top-of-stack data value (before any pop) |
| ret_i | input | 1 | Return flag of the current non-branch word |
| fetch_addr_o | output | 10 | Program counter, the top return-stack entry |
| drop_o | output | 1 | Data-stack pop request for this step |

## Verification
The hardest state to reach is deep call nesting. To get there, the bench needs a chain of fifteen taken calls, each executed from the target of the previous one, and then fifteen returns. Each return must come back to a different saved address. The bench records the fetch address before every call and checks the returns against those records in reverse order. Ignoring the return flag on a branch word is only visible inside a live call frame, so the bench raises that flag on an untaken branch inside a call. It then shows that the following real return still lands on the caller.

// File: rtl/flow_pkg.sv
package flow_pkg;
   typedef enum logic [1:0] {
      OP_SEQ  = 2'd0,
      OP_JUMP = 2'd1,
      OP_CALL = 2'd2,
      OP_RET  = 2'd3
   } flow_op_e;

   typedef enum logic [2:0] {
      PR_NEVER   = 3'd0,
      PR_NEG     = 3'd1,
      PR_ZERO    = 3'd2,
      PR_NONPOS  = 3'd3,
      PR_POS     = 3'd4,
      PR_NONZERO = 3'd5,
      PR_NONNEG  = 3'd6,
      PR_ALWAYS  = 3'd7
   } flow_pred_e;
endpackage

// File: rtl/flow_decode.sv
module flow_decode
   import flow_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic [ADDR_W+5:0] instr_i,
   output logic              is_branch_o,
   output logic              is_call_o,
   output flow_pred_e        pred_o,
   output logic              drop_o,
   output logic [ADDR_W-1:0] dest_o
);
   localparam int INSTR_W = ADDR_W + 6;

   assign is_branch_o = instr_i[INSTR_W-1];
   assign is_call_o   = instr_i[INSTR_W-1] & instr_i[INSTR_W-2];
   assign pred_o      = flow_pred_e'(instr_i[INSTR_W-3:INSTR_W-5]);
   assign drop_o      = instr_i[ADDR_W];
   assign dest_o      = instr_i[ADDR_W-1:0];
endmodule

// File: rtl/flow_cond.sv
module flow_cond
   import flow_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  flow_pred_e        pred_i,
   input  logic [DATA_W-1:0] tos_i,
   output logic              take_o
);
   logic neg, zero;

   assign neg  = tos_i[DATA_W-1];
   assign zero = (tos_i == '0);

   always_comb begin
      unique case (pred_i)
         PR_NEVER:   take_o = 1'b0;
         PR_NEG:     take_o = neg;
         PR_ZERO:    take_o = zero;
         PR_NONPOS:  take_o = neg | zero;
         PR_POS:     take_o = ~neg & ~zero;
         PR_NONZERO: take_o = ~zero;
         PR_NONNEG:  take_o = ~neg;
         default:    take_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/flow_ret_stack.sv
module flow_ret_stack
   import flow_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  flow_op_e          op_i,
   input  logic [ADDR_W-1:0] target_i,
   output logic [ADDR_W-1:0] top_o
);
   localparam int PW = $clog2(DEPTH);

   logic [ADDR_W-1:0] mem_q [DEPTH];
   logic [ADDR_W-1:0] mem_d [DEPTH];
   logic [PW-1:0]     ptr_q, ptr_d, ptr_up, ptr_dn;
   logic [ADDR_W-1:0] top_inc;

   assign top_o   = mem_q[ptr_q];
   assign top_inc = top_o + ADDR_W'(1);
   assign ptr_up  = ptr_q + PW'(1);
   assign ptr_dn  = ptr_q - PW'(1);

   always_comb begin
      mem_d = mem_q;
      ptr_d = ptr_q;
      if (step_i) begin
         unique case (op_i)
            OP_SEQ:  mem_d[ptr_q] = top_inc;
            OP_JUMP: mem_d[ptr_q] = target_i;
            OP_CALL: begin
               mem_d[ptr_q]  = top_inc;
               mem_d[ptr_up] = target_i;
               ptr_d         = ptr_up;
            end
            default: ptr_d = ptr_dn;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else begin
         ptr_q <= ptr_d;
         mem_q <= mem_d;
      end
   end

   // R5: a taken call advances the pointer and lands on the target
   a_r5_call_push: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && op_i == OP_CALL) |=> (ptr_q == $past(ptr_q) + PW'(1)) && (top_o == $past(target_i)));

   // R8: a return retreats the pointer by one entry
   a_r8_ret_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && op_i == OP_RET) |=> ptr_q == $past(ptr_q) - PW'(1));

   // R4: a taken jump replaces the top and keeps the pointer
   a_r4_jump_top: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && op_i == OP_JUMP) |=> (top_o == $past(target_i)) && $stable(ptr_q));

   // R2: sequential flow advances by one
   a_r2_seq_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && op_i == OP_SEQ) |=> (top_o == $past(top_o) + ADDR_W'(1)) && $stable(ptr_q));

   // R9: idle cycles hold all state visible at the output
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(ptr_q) && $stable(top_o));
endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer
   import flow_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 10,
   parameter int DEPTH  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                step_i,
   input  logic [ADDR_W+5:0]   instr_i,
   input  logic [DATA_W-1:0]   tos_i,
   input  logic                ret_i,
   output logic [ADDR_W-1:0]   fetch_addr_o,
   output logic                drop_o
);
   localparam int INSTR_W = ADDR_W + 6;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("flow_sequencer: DEPTH must be a power of two of at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("flow_sequencer: ADDR_W must be positive");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("flow_sequencer: DATA_W must be at least 2");
   end

   logic              is_branch, is_call, drop_bit, take;
   flow_pred_e        pred;
   logic [ADDR_W-1:0] dest;
   flow_op_e          op;

   flow_decode #(.ADDR_W(ADDR_W)) u_decode (
      .instr_i     (instr_i),
      .is_branch_o (is_branch),
      .is_call_o   (is_call),
      .pred_o      (pred),
      .drop_o      (drop_bit),
      .dest_o      (dest)
   );

   flow_cond #(.DATA_W(DATA_W)) u_cond (
      .pred_i (pred),
      .tos_i  (tos_i),
      .take_o (take)
   );

   always_comb begin
      if (is_branch) begin
         if (!take)        op = OP_SEQ;
         else if (is_call) op = OP_CALL;
         else              op = OP_JUMP;
      end else begin
         op = ret_i ? OP_RET : OP_SEQ;
      end
   end

   assign drop_o = step_i & is_branch & drop_bit;

   flow_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_i   (step_i),
      .op_i     (op),
      .target_i (dest),
      .top_o    (fetch_addr_o)
   );

   // R7: a pop request only accompanies a stepped branch word
   a_r7_drop_branch_only: assert property (@(posedge clk) disable iff (!rst_n)
      drop_o |-> (step_i && instr_i[INSTR_W-1]));

   // R6: an untaken branch falls through to the next address
   a_r6_untaken_falls: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && instr_i[INSTR_W-1] && instr_i[INSTR_W-3:INSTR_W-5] == 3'd0)
      |=> fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(1));
endmodule

// File: tb/flow_sequencer_bench.sv
module flow_sequencer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step = 1'b0;
   logic [15:0] instr = '0;
   logic [15:0] tos = '0;
   logic        ret = 1'b0;
   logic [9:0]  fetch;
   logic        drop;
   logic        drop_seen;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   flow_sequencer u_flow_sequencer (
      .clk(clk), .rst_n(rst_n), .step_i(step), .instr_i(instr),
      .tos_i(tos), .ret_i(ret), .fetch_addr_o(fetch), .drop_o(drop)
   );

   // {pred[2:0], tos[15:0], expected taken}
   localparam int NV = 17;
   localparam logic [19:0] VEC [NV] = '{
      {3'd0, 16'h0000, 1'b0}, {3'd0, 16'hFFFF, 1'b0},
      {3'd1, 16'h8000, 1'b1}, {3'd1, 16'h0000, 1'b0},
      {3'd2, 16'h0000, 1'b1}, {3'd2, 16'h0001, 1'b0},
      {3'd3, 16'hFFFF, 1'b1}, {3'd3, 16'h0000, 1'b1},
      {3'd3, 16'h0001, 1'b0}, {3'd4, 16'h7FFF, 1'b1},
      {3'd4, 16'h0000, 1'b0}, {3'd4, 16'h8000, 1'b0},
      {3'd5, 16'h0000, 1'b0}, {3'd5, 16'h8000, 1'b1},
      {3'd6, 16'h0000, 1'b1}, {3'd6, 16'hFFFF, 1'b0},
      {3'd7, 16'h8000, 1'b1}
   };

   function automatic logic [15:0] br(input logic call, input logic [2:0] p,
                                      input logic d, input logic [9:0] a);
      return {1'b1, call, p, d, a};
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_step(input logic [15:0] w, input logic [15:0] t, input logic r);
      @(negedge clk);
      instr = w; tos = t; ret = r; step = 1'b1;
      #1 drop_seen = drop;
      @(negedge clk);
      step = 1'b0; instr = '0; ret = 1'b0;
   endtask

   initial begin
      logic [9:0] saved [16];
      repeat (3) @(negedge clk);
      chk("R1 reset fetch", 16'(fetch), 16'h0);
      chk("R1 reset drop", 16'(drop), 16'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: sequential advance
      for (int i = 1; i <= 3; i++) begin
         do_step(16'h0000, 16'h0, 1'b0);
         chk("R2 seq", 16'(fetch), 16'(i));
      end
      // R9: idle holds
      repeat (4) @(negedge clk);
      chk("R9 idle", 16'(fetch), 16'h3);

      // R3 R4 R5 R6 R7: predicate table walk
      for (int i = 0; i < NV; i++) begin
         logic [2:0]  p;
         logic [15:0] t;
         logic        tk, cl, d;
         p = VEC[i][19:17]; t = VEC[i][16:1]; tk = VEC[i][0];
         cl = i[0]; d = i[1];
         do_step(br(1'b0, 3'd7, 1'b0, 10'h100), 16'h0, 1'b0);
         chk("R4 jump always", 16'(fetch), 16'h100);
         do_step(br(cl, p, d, 10'h2A0), t, 1'b0);
         chk("R7 drop on branch", 16'(drop_seen), 16'(d));
         chk(tk ? "R3 taken" : "R6 untaken", 16'(fetch), tk ? 16'h2A0 : 16'h101);
         if (cl && tk) begin
            do_step(16'h0000, 16'h0, 1'b1);
            chk("R5 call returns", 16'(fetch), 16'h101);
         end
      end

      // R8: return flag ignored on a branch word, inside a call frame
      do_step(br(1'b0, 3'd7, 1'b0, 10'h050), 16'h0, 1'b0);
      do_step(br(1'b1, 3'd7, 1'b0, 10'h300), 16'h0, 1'b0);
      chk("R5 call target", 16'(fetch), 16'h300);
      do_step(br(1'b0, 3'd0, 1'b1, 10'h123), 16'h0, 1'b1);
      chk("R8 ret ignored on branch", 16'(fetch), 16'h301);
      chk("R7 drop when untaken", 16'(drop_seen), 16'h1);
      do_step(16'h0000, 16'h0, 1'b1);
      chk("R8 return", 16'(fetch), 16'h051);
      do_step(16'h1234, 16'h0, 1'b0);
      chk("R7 no drop on plain", 16'(drop_seen), 16'h0);

      // R10: fifteen nested calls then fifteen returns
      do_step(br(1'b0, 3'd7, 1'b0, 10'h020), 16'h0, 1'b0);
      for (int k = 1; k <= 15; k++) begin
         saved[k] = fetch;
         do_step(br(1'b1, 3'd7, 1'b0, 10'(10'h040 + k * 16)), 16'h0, 1'b0);
         chk("R10 nest call", 16'(fetch), 16'(10'h040 + k * 16));
      end
      for (int k = 15; k >= 1; k--) begin
         do_step(16'h0000, 16'h0, 1'b1);
         chk("R10 nest return", 16'(fetch), 16'(saved[k] + 10'd1));
      end

      // R2: wrap at the top of the address space
      do_step(br(1'b0, 3'd7, 1'b0, 10'h3FF), 16'h0, 1'b0);
      do_step(16'h0000, 16'h0, 1'b0);
      chk("R2 wrap", 16'(fetch), 16'h000);

      // R1: reset mid-run
      do_step(br(1'b1, 3'd7, 1'b0, 10'h222), 16'h0, 1'b0);
      rst_n = 1'b0;
      #2;
      chk("R1 reset again", 16'(fetch), 16'h0);
      @(negedge clk);
      rst_n = 1'b1;
      do_step(16'h0000, 16'h0, 1'b0);
      chk("R1 pointer cleared", 16'(fetch), 16'h1);

      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule